// File: doc/BRIEF.md
# Adaptive USB Symbol Timing Recovery

This block turns an oversampled pair of USB low- or full-speed data lines into a stream of NRZI-decoded bits. Every cycle of the fast sample clock it classifies the line pair as J, K, single-ended zero (SE0) or single-ended one (SE1). While idle it watches for a J-to-K change, which starts a packet. From then on it places one sample near the middle of each symbol and a second one where the symbol's leading transition should fall.

The transition sample is an early/late detector. When a symbol change is seen and the transition sample already shows the new symbol, the sender is running fast. The bit period is then shortened slightly and the sampling phase pulled in. In the opposite case the period is lengthened and the phase pushed out. This lets the receiver follow a sender whose rate is off nominal for a whole long packet, where a fixed count of samples per bit would slip. An SE0 followed by J ends the packet and restores the nominal period.

The block is placed behind an input synchroniser and ahead of the bit-unstuffing and packet logic. It reports one-cycle strobes for each decoded bit and for the packet start and end.

Top module: `usb_sym_tracker`

## Requirements
- R1: Line classification. Both lines low is SE0 and both lines high is SE1. With `speed_low_i` = 0, J is D+ high and D- low. With `speed_low_i` = 1, J is D- high and D+ low. K is the other single-line-high state.
- R2: While idle, a sample of K directly after a sample of J produces exactly one `sop_o` pulse, one cycle after the K sample. Idle J or SE0 stretches without a J-to-K change produce no pulse.
- R3: The first `bit_valid_o` of a packet comes floor(P/2 + 1/2) cycles after the `sop_o` pulse, where P is the nominal period in samples (`NOM_PERIOD` / 2^`FRAC_W`).
- R4: Each J or K centre sample gives one one-cycle `bit_valid_o`. `bit_o` is 0 when the symbol differs from the previous centre symbol and 1 when it is the same. The first symbol of a packet is compared against J.
- R5: Each centre sample follows the previous one by the current period. The period and phase change only when the symbol changed and the transition sample is J or K. If the transition sample equals the new symbol, the period drops by about 1/1000 and the next centre moves earlier by about 1/100 of the period. Otherwise both move the other way.
- R6: A packet sent up to 1.5 % off the nominal rate is decoded without bit error over at least 120 bits, and one sent 0.25 % off is decoded over at least 800 bits.
- R7: The bit period stays within about ±3 % (1/32 − 1/1024) of nominal at all times.
- R8: An SE0 centre sample yields no bit. A J centre sample after one or more SE0 centre samples yields one `eop_o` pulse and returns to idle with the period reset to nominal.
- R9: An SE1 centre sample in a packet, or a K or SE1 centre sample after SE0, returns to idle without any bit or `eop_o`. The next idle J-to-K change starts a new packet.
- R10: After reset all outputs are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_low_i | input | 1 | 1 selects low-speed J/K polarity, 0 full-speed |
| dp_i | input | 1 | Synchronised D+ sample |
| dm_i | input | 1 | Synchronised D- sample |
| bit_o | output | 1 | NRZI-decoded bit, valid with `bit_valid_o` |
| bit_valid_o | output | 1 | One-cycle strobe per decoded bit |
| sop_o | output | 1 | One-cycle start-of-packet pulse |
| eop_o | output | 1 | One-cycle end-of-packet pulse |

## Verification
A wrong period or phase register does not show up at once. It appears as slowly drifting `bit_valid_o` spacing and, once the drift passes half a bit, as a dropped, doubled or inverted bit. That can take tens to hundreds of bits, so the bench runs long off-rate packets and compares whole bit streams. A wrong idle/data/end-of-packet state shows within one symbol as a missing or extra `sop_o`/`eop_o` or a bit count that does not match. The first-bit delay after `sop_o` exposes a wrong starting phase directly.

// File: rtl/usb_trk_pkg.sv
package usb_trk_pkg;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'd0,
        SYM_J   = 2'd1,
        SYM_K   = 2'd2,
        SYM_SE1 = 2'd3
    } line_sym_e;

    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_EARLY = 2'd1,
        ADJ_LATE  = 2'd2
    } adj_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_EOPW = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic sop;
        logic eop;
        logic valid;
        logic data;
    } rx_out_s;

    // Classify a line pair; low speed swaps which single-ended-high state is idle.
    function automatic line_sym_e classify_line(logic dp, logic dm, logic low_speed);
        line_sym_e s;
        case ({dp, dm})
            2'b00:   s = SYM_SE0;
            2'b11:   s = SYM_SE1;
            2'b10:   s = low_speed ? SYM_K : SYM_J;
            default: s = low_speed ? SYM_J : SYM_K;
        endcase
        return s;
    endfunction

    function automatic logic is_data_sym(line_sym_e s);
        return (s == SYM_J) || (s == SYM_K);
    endfunction

endpackage

// File: rtl/usb_line_sym_decode.sv
module usb_line_sym_decode
    import usb_trk_pkg::*;
(
    input  logic      dp_i,
    input  logic      dm_i,
    input  logic      speed_low_i,
    output line_sym_e sym_o
);

    always_comb begin
        sym_o = classify_line(dp_i, dm_i, speed_low_i);
    end

endmodule

// File: rtl/usb_bit_clock_track.sv
module usb_bit_clock_track
    import usb_trk_pkg::*;
#(
    parameter int PERIOD_W   = 24,
    parameter int FRAC_W     = 16,
    parameter int NOM_PERIOD = 1365333
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic sop_i,
    input  adj_e adj_i,
    output logic centre_o,
    output logic edge_o
);

    localparam int RW = PERIOD_W + 1;
    localparam logic [RW-1:0] ONE_X   = RW'(1) << FRAC_W;
    localparam logic [RW-1:0] NOM_X   = RW'(NOM_PERIOD);
    localparam logic [RW-1:0] SPAN_X  = (NOM_X >> 5) - (NOM_X >> 10);
    localparam logic [RW-1:0] P_MIN_X = NOM_X - SPAN_X;
    localparam logic [RW-1:0] P_MAX_X = NOM_X + SPAN_X;
    localparam logic [RW-1:0] SOP_X   = (NOM_X >> 1) + (ONE_X >> 1) - ONE_X;

    logic [PERIOD_W-1:0] period_q;
    logic [RW-1:0]       rel_q;

    logic [RW-1:0] per_ext, half_ext, step_p, p_raw, p_new, ph, rel_adv;

    always_comb begin
        per_ext  = {1'b0, period_q};
        half_ext = per_ext >> 1;
        // about one thousandth of the period
        step_p   = (per_ext >> 10) + (per_ext >> 16) + (per_ext >> 17);
        case (adj_i)
            ADJ_EARLY: p_raw = per_ext - step_p;
            ADJ_LATE:  p_raw = per_ext + step_p;
            default:   p_raw = per_ext;
        endcase
        if (p_raw < P_MIN_X)      p_new = P_MIN_X;
        else if (p_raw > P_MAX_X) p_new = P_MAX_X;
        else                      p_new = p_raw;
        // about one hundredth of the updated period
        ph = (p_new >> 7) + (p_new >> 9) + (p_new >> 12);
        rel_adv = rel_q + p_new - ONE_X;
        if (adj_i == ADJ_EARLY)     rel_adv = rel_adv - ph;
        else if (adj_i == ADJ_LATE) rel_adv = rel_adv + ph;
        centre_o = active_i && (rel_q < ONE_X);
        edge_o   = active_i && (rel_q >= half_ext) && (rel_q < half_ext + ONE_X);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= NOM_X[PERIOD_W-1:0];
            rel_q    <= '0;
        end else if (!active_i) begin
            period_q <= NOM_X[PERIOD_W-1:0];
            rel_q    <= sop_i ? SOP_X : '0;
        end else if (centre_o) begin
            period_q <= p_new[PERIOD_W-1:0];
            rel_q    <= rel_adv;
        end else begin
            rel_q    <= rel_q - ONE_X;
        end
    end

    assert_period_range_R7: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, period_q} >= P_MIN_X) && ({1'b0, period_q} <= P_MAX_X));

    assert_hold_without_adjust_R5: assert property (@(posedge clk) disable iff (rst)
        (active_i && centre_o && adj_i == ADJ_NONE) |=> (period_q == $past(period_q)));

    assert_early_shrinks_R5: assert property (@(posedge clk) disable iff (rst)
        (active_i && centre_o && adj_i == ADJ_EARLY && {1'b0, period_q} > P_MIN_X)
        |=> (period_q < $past(period_q)));

    assert_late_grows_R5: assert property (@(posedge clk) disable iff (rst)
        (active_i && centre_o && adj_i == ADJ_LATE && {1'b0, period_q} < P_MAX_X)
        |=> (period_q > $past(period_q)));

    assert_idle_nominal_R8: assert property (@(posedge clk) disable iff (rst)
        (!active_i && !$past(active_i)) |-> ({1'b0, period_q} == NOM_X));

endmodule

// File: rtl/usb_rx_sym_fsm.sv
module usb_rx_sym_fsm
    import usb_trk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_sym_e sym_i,
    input  logic      centre_i,
    input  logic      edge_i,
    output logic      active_o,
    output logic      sop_now_o,
    output adj_e      adj_o,
    output logic      bit_o,
    output logic      bit_valid_o,
    output logic      sop_o,
    output logic      eop_o
);

    rx_state_e state_q, state_d;
    line_sym_e prev_q, prev_d;
    line_sym_e edge_q, edge_d;
    rx_out_s   out_q, out_d;

    always_comb begin
        active_o  = (state_q != ST_IDLE);
        sop_now_o = (state_q == ST_IDLE) && (prev_q == SYM_J) && (sym_i == SYM_K);
        adj_o     = ADJ_NONE;
        state_d   = state_q;
        prev_d    = prev_q;
        edge_d    = edge_q;
        out_d     = '0;
        case (state_q)
            ST_IDLE: begin
                if (sop_now_o) begin
                    state_d   = ST_DATA;
                    edge_d    = SYM_K;
                    out_d.sop = 1'b1;
                end else begin
                    prev_d    = sym_i;
                end
            end
            ST_DATA: begin
                if (edge_i) edge_d = sym_i;
                if (centre_i) begin
                    prev_d = sym_i;
                    if (is_data_sym(sym_i)) begin
                        out_d.valid = 1'b1;
                        out_d.data  = (sym_i == prev_q);
                        if ((sym_i != prev_q) && is_data_sym(edge_q))
                            adj_o = (edge_q == sym_i) ? ADJ_EARLY : ADJ_LATE;
                    end else if (sym_i == SYM_SE0) begin
                        state_d = ST_EOPW;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: begin
                if (centre_i) begin
                    prev_d = sym_i;
                    if (sym_i == SYM_J) begin
                        out_d.eop = 1'b1;
                        state_d   = ST_IDLE;
                    end else if (sym_i != SYM_SE0) begin
                        state_d   = ST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            prev_q  <= SYM_SE0;
            edge_q  <= SYM_SE0;
            out_q   <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= prev_d;
            edge_q  <= edge_d;
            out_q   <= out_d;
        end
    end

    assign bit_o       = out_q.data;
    assign bit_valid_o = out_q.valid;
    assign sop_o       = out_q.sop;
    assign eop_o       = out_q.eop;

    assert_pulses_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_q.sop, out_q.eop, out_q.valid}));

    assert_sop_enters_data_R2: assert property (@(posedge clk) disable iff (rst)
        out_q.sop |-> (state_q == ST_DATA));

    assert_eop_back_to_idle_R8: assert property (@(posedge clk) disable iff (rst)
        out_q.eop |-> (state_q == ST_IDLE && $past(state_q) == ST_EOPW));

    assert_no_adjust_outside_data_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_DATA) |-> (adj_o == ADJ_NONE));

    assert_bits_only_in_data_R4: assert property (@(posedge clk) disable iff (rst)
        out_q.valid |-> ($past(state_q) == ST_DATA));

endmodule

// File: rtl/usb_sym_tracker.sv
module usb_sym_tracker
    import usb_trk_pkg::*;
#(
    parameter int PERIOD_W   = 24,
    parameter int FRAC_W     = 16,
    parameter int NOM_PERIOD = 1365333
) (
    input  logic clk,
    input  logic rst,
    input  logic speed_low_i,
    input  logic dp_i,
    input  logic dm_i,
    output logic bit_o,
    output logic bit_valid_o,
    output logic sop_o,
    output logic eop_o
);

    line_sym_e sym;
    logic      active, sop_now, centre, edge_hit;
    adj_e      adj;

    usb_line_sym_decode u_decode (
        .dp_i        (dp_i),
        .dm_i        (dm_i),
        .speed_low_i (speed_low_i),
        .sym_o       (sym)
    );

    usb_bit_clock_track #(
        .PERIOD_W   (PERIOD_W),
        .FRAC_W     (FRAC_W),
        .NOM_PERIOD (NOM_PERIOD)
    ) u_track (
        .clk      (clk),
        .rst      (rst),
        .active_i (active),
        .sop_i    (sop_now),
        .adj_i    (adj),
        .centre_o (centre),
        .edge_o   (edge_hit)
    );

    usb_rx_sym_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sym_i       (sym),
        .centre_i    (centre),
        .edge_i      (edge_hit),
        .active_o    (active),
        .sop_now_o   (sop_now),
        .adj_o       (adj),
        .bit_o       (bit_o),
        .bit_valid_o (bit_valid_o),
        .sop_o       (sop_o),
        .eop_o       (eop_o)
    );

endmodule

// File: tb/usb_sym_tracker_tb_top.sv
module usb_sym_tracker_tb_top;

    localparam int NOM  = 1365333;
    localparam int FRAC = 16;
    localparam int MAXB = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spd = 1'b0;
    logic dp  = 1'b1;
    logic dm  = 1'b0;
    logic bit_o, bit_valid_o, sop_o, eop_o;

    always #2 clk = ~clk;

    usb_sym_tracker #(.PERIOD_W(24), .FRAC_W(FRAC), .NOM_PERIOD(NOM)) dut_i (
        .clk (clk), .rst (rst), .speed_low_i (spd), .dp_i (dp), .dm_i (dm),
        .bit_o (bit_o), .bit_valid_o (bit_valid_o), .sop_o (sop_o), .eop_o (eop_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: cumulative records, sampled away from the active edge
    int got_bits [MAXB];
    int bit_cyc  [MAXB];
    int got_n = 0, sop_n = 0, eop_n = 0, sop_cyc = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (sop_o) begin sop_n++; sop_cyc = cyc; end
            if (eop_o) eop_n++;
            if (bit_valid_o) begin
                if (got_n < MAXB) begin
                    got_bits[got_n] = int'(bit_o);
                    bit_cyc[got_n]  = cyc;
                end
                got_n++;
            end
        end
    end

    int checks = 0, errors = 0;
    int exp_b [MAXB];
    int exp_n;
    real tx_acc, tx_per;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // J/K/SE0/SE1 codes 1/2/0/3, polarity per speed (R1)
    task automatic drive_sym(input int s);
        case (s)
            0: begin dp = 1'b0; dm = 1'b0; end
            3: begin dp = 1'b1; dm = 1'b1; end
            1: begin dp = ~spd; dm = spd; end
            default: begin dp = spd; dm = ~spd; end
        endcase
    endtask

    task automatic hold_sym(input int s);
        real nx;
        int n;
        nx = tx_acc + tx_per;
        n  = $rtoi(nx) - $rtoi(tx_acc);
        tx_acc = nx;
        drive_sym(s);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_cycles(input int n);
        drive_sym(1);
        repeat (n) @(negedge clk);
    endtask

    function automatic int first_gap();
        return ((NOM / 2) + (1 << (FRAC - 1))) >>> FRAC;
    endfunction

    // Build sync + stuffed random payload into exp_b
    function automatic void build_bits(input int nbits);
        int ones;
        exp_n = 0;
        for (int i = 0; i < 7; i++) begin exp_b[exp_n] = 0; exp_n++; end
        exp_b[exp_n] = 1; exp_n++;
        ones = 1;
        for (int i = 0; i < nbits; i++) begin
            int b;
            b = int'($urandom_range(0, 1));
            exp_b[exp_n] = b; exp_n++;
            ones = b ? ones + 1 : 0;
            if (ones == 6) begin exp_b[exp_n] = 0; exp_n++; ones = 0; end
        end
    endfunction

    // tail: 0 = SE0 SE0 J, 1 = SE1 abort, 2 = SE0 then K abort
    task automatic send_packet(input int nbits, input real err, input int tail,
                               input string tag);
        int b0, s0, e0, cur, mism, expected_eop;
        build_bits(nbits);
        b0 = got_n; s0 = sop_n; e0 = eop_n;
        tx_per = (real'(NOM) / real'(1 << FRAC)) * (1.0 + err);
        tx_acc = 0.0;
        cur = 1;
        for (int i = 0; i < exp_n; i++) begin
            if (exp_b[i] == 0) cur = (cur == 1) ? 2 : 1;
            hold_sym(cur);
        end
        if (tail == 0) begin hold_sym(0); hold_sym(0); hold_sym(1); end
        else if (tail == 1) begin hold_sym(3); end
        else begin hold_sym(0); hold_sym(2); end
        idle_cycles(60);
        expected_eop = (tail == 0) ? 1 : 0;
        check(sop_n - s0 == 1, "R2", {tag, " sop count"}, sop_n - s0, 1);
        check(eop_n - e0 == expected_eop, (tail == 0) ? "R8" : "R9",
              {tag, " eop count"}, eop_n - e0, expected_eop);
        check(got_n - b0 == exp_n, "R4", {tag, " bit count"}, got_n - b0, exp_n);
        mism = 0;
        if (got_n - b0 == exp_n) begin
            for (int i = 0; i < exp_n; i++)
                if (got_bits[b0 + i] != exp_b[i]) mism++;
        end else mism = -1;
        check(mism == 0, "R6", {tag, " bit mismatches"}, mism, 0);
        if (got_n > b0)
            check(bit_cyc[b0] - sop_cyc == first_gap(), "R3", {tag, " first bit delay"},
                  bit_cyc[b0] - sop_cyc, first_gap());
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int s0;
        void'($urandom(32'd20240611));
        drive_sym(1);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({bit_o, bit_valid_o, sop_o, eop_o} == 4'b0, "R10", "outputs after reset",
              int'({bit_o, bit_valid_o, sop_o, eop_o}), 0);

        // R2: idle J and SE0 stretches make no start pulse
        s0 = sop_n;
        idle_cycles(100);
        drive_sym(0); repeat (10) @(negedge clk);
        idle_cycles(50);
        check(sop_n == s0, "R2", "no sop without J-to-K", sop_n - s0, 0);

        send_packet(64,  0.0,     0, "nominal");
        send_packet(120, -0.015,  0, "fast 1.5%");
        send_packet(120, 0.015,   0, "slow 1.5%");
        send_packet(40,  0.0,     0, "nominal after slow (R8 reset)");
        send_packet(800, -0.0025, 0, "fast 0.25%");
        send_packet(800, 0.0025,  0, "slow 0.25%");

        // R1: low-speed polarity
        spd = 1'b1; drive_sym(1); repeat (20) @(negedge clk);
        send_packet(80, 0.01, 0, "low speed R1");
        spd = 1'b0; drive_sym(1); repeat (20) @(negedge clk);

        // R9 aborts
        send_packet(8, 0.0, 1, "SE1 abort");
        send_packet(8, 0.0, 2, "SE0-K abort");
        send_packet(30, 0.0, 0, "after aborts");

        for (int k = 0; k < 4; k++) begin
            int n;
            real e;
            n = int'($urandom_range(40, 150));
            e = (real'($urandom_range(0, 300)) - 150.0) / 10000.0;
            send_packet(n, e, 0, "random");
        end
        finish_run();
    end

endmodule